// File: doc/BRIEF.md
# Machine trap setup CSR file

This block holds the trap-setup state of a small hart: the machine status word, the interrupt-enable and interrupt-pending words, the interrupt and exception delegation words, and the machine and supervisor trap-vector bases. The instruction pipeline computes the merged write value for a register and raises that register's strobe for one cycle. The block keeps only the fields that are writable and only the values that are legal. Its read outputs come straight from the stored state. The supervisor status, enable and pending words are not stored separately. Each one is a masked window onto the corresponding machine word.

The pending word mixes two sources. Software may set or clear the delegable supervisor bits. Hardware drives any bit it claims through a side input, and a claimed bit follows that input on every clock edge. A status write that changes any translation-related field raises a one-cycle pulse, so that address-translation caches can be flushed. The pipeline raises at most one strobe per cycle.

Top module: `mtrap_csr_file`

## Requirements
- R1: Under reset every output reads zero, except the machine status word, which reads 0x0000_1800 (the previous-privilege field in bits 12:11 holds 3). The flush pulse is low.
- R2: A machine status write changes only bits 1, 3, 5, 7, 8, 11-14 and 17-22 (mask 0x007E_79AA). Every other stored bit keeps its value, so bits 0, 4 and 15-16 always read 0.
- R3: Status bit 31 reads 1 exactly when bits 14:13 hold 3 or bits 16:15 hold 3. After a status write it reflects the written value.
- R4: The supervisor status view reads the machine status word ANDed with 0x800D_E133. A write to the view first merges the data into the machine word under that mask, then applies the R2 rule.
- R5: A write to either trap-vector word whose bits 1:0 are 0 or 1 stores the whole word. A write whose bits 1:0 are 2 or 3 leaves the word unchanged.
- R6: An interrupt-delegation write keeps only bits 1, 5 and 9 (mask 0x222). A machine interrupt-enable write keeps only bits 1, 3, 5, 7, 9 and 11 (mask 0xAAA).
- R7: The supervisor enable view reads enable AND delegation. A write to it replaces only the enable bits that are currently delegated.
- R8: On a machine pending write, the bits in (write mask AND 0x222 AND NOT claim) take the write data. A supervisor pending write also ANDs that set with the delegation word. On every edge, each bit in (claim AND 0xAAA) takes the value of the hardware pending input. The supervisor pending view reads pending AND delegation.
- R9: An exception-delegation write keeps only cause bits 0-13 and 15 (mask 0xBFFF).
- R10: The flush pulse is high for the one cycle after a status write (either view) that changes bit 19, bits 12:11, bit 17 or bit 18. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | XLEN | Merged write value for the strobed register |
| wr_mask | input | XLEN | Bit mask for pending-word writes |
| we_stat_m | input | 1 | Write machine status |
| we_stat_s | input | 1 | Write supervisor status view |
| we_ien_m | input | 1 | Write machine interrupt enable |
| we_ien_s | input | 1 | Write supervisor enable view |
| we_ipend_m | input | 1 | Write machine interrupt pending |
| we_ipend_s | input | 1 | Write supervisor pending view |
| we_ideleg | input | 1 | Write interrupt delegation |
| we_edeleg | input | 1 | Write exception delegation |
| we_tvec_m | input | 1 | Write machine trap vector |
| we_tvec_s | input | 1 | Write supervisor trap vector |
| hw_pend | input | XLEN | Hardware pending levels |
| hw_claim | input | XLEN | Pending bits owned by hardware |
| rd_stat_m | output | XLEN | Machine status |
| rd_stat_s | output | XLEN | Supervisor status view |
| rd_ien_m | output | XLEN | Machine interrupt enable |
| rd_ien_s | output | XLEN | Supervisor enable view |
| rd_ipend_m | output | XLEN | Machine interrupt pending |
| rd_ipend_s | output | XLEN | Supervisor pending view |
| rd_ideleg | output | XLEN | Interrupt delegation |
| rd_edeleg | output | XLEN | Exception delegation |
| rd_tvec_m | output | XLEN | Machine trap vector |
| rd_tvec_s | output | XLEN | Supervisor trap vector |
| flush_req | output | 1 | One-cycle translation flush pulse |

## Verification
Each write is captured on the rising edge where its strobe is high, and the read outputs show the new value right after that edge. The flush pulse is registered on the same edge, so it is high during the following cycle only. A claimed pending bit takes the hardware level present at each edge. The bench drives every stimulus at the falling edge, lets exactly one rising edge pass, and compares all outputs at the next falling edge against its model. An idle cycle is checked the same way, which confirms that the pulse drops after one cycle.

// File: rtl/mtcsr_pkg.sv
package mtcsr_pkg;
   // field positions decoded by neighbouring logic
   localparam int F_SUP_IE    = 1;
   localparam int F_MCH_IE    = 3;
   localparam int F_SUP_PIE   = 5;
   localparam int F_MCH_PIE   = 7;
   localparam int F_SUP_PP    = 8;
   localparam int F_MCH_PP    = 11;
   localparam int F_FPU_ST    = 13;
   localparam int F_EXT_ST    = 15;
   localparam int F_MOD_PRIV  = 17;
   localparam int F_USR_MEM   = 18;
   localparam int F_EXEC_RD   = 19;
   localparam int F_TRAP_VM   = 20;
   localparam int F_TIME_WAIT = 21;
   localparam int F_TRAP_SRET = 22;

   localparam logic [63:0] STAT_WMASK =
      (64'd1 << F_SUP_IE) | (64'd1 << F_MCH_IE) | (64'd1 << F_SUP_PIE) |
      (64'd1 << F_MCH_PIE) | (64'd1 << F_SUP_PP) | (64'd3 << F_MCH_PP) |
      (64'd3 << F_FPU_ST) | (64'd1 << F_MOD_PRIV) | (64'd1 << F_USR_MEM) |
      (64'd1 << F_EXEC_RD) | (64'd1 << F_TRAP_VM) | (64'd1 << F_TIME_WAIT) |
      (64'd1 << F_TRAP_SRET);
   // supervisor window, the summary bit is added per width
   localparam logic [63:0] STAT_SVIEW = 64'h0000_0000_000D_E133;
   localparam logic [63:0] STAT_FLUSH =
      (64'd1 << F_EXEC_RD) | (64'd3 << F_MCH_PP) | (64'd1 << F_MOD_PRIV) |
      (64'd1 << F_USR_MEM);
   localparam logic [63:0] STAT_RESET = 64'd3 << F_MCH_PP;

   localparam logic [63:0] INT_DELEGABLE = 64'h222;
   localparam logic [63:0] INT_ALL       = 64'hAAA;
   localparam logic [63:0] EXC_DELEGABLE = 64'hBFFF;
endpackage

// File: rtl/mtcsr_mreg.sv
module mtcsr_mreg #(
   parameter int XLEN = 32,
   parameter logic [XLEN-1:0] MASK = '1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] q_o
);
   logic [XLEN-1:0] q;

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wd & MASK;
   end
   assign q_o = q;

   AST_MREG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q_o)); // R9
endmodule

// File: rtl/mtcsr_tvec.sv
module mtcsr_tvec #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] vec_o
);
   logic [XLEN-1:0] q;
   logic            mode_ok;

   // modes 0 and 1 only; reserved modes drop the whole write
   assign mode_ok = (wd[1] == 1'b0);

   always_ff @(posedge clk) begin
      if (rst)                q <= '0;
      else if (we && mode_ok) q <= wd;
   end
   assign vec_o = q;

   AST_TVEC_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      vec_o[1] == 1'b0); // R5
   AST_TVEC_DROP: assert property (@(posedge clk) disable iff (rst)
      (we && wd[1]) |=> $stable(vec_o)); // R5
endmodule

// File: rtl/mtcsr_status.sv
module mtcsr_status
   import mtcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we_m,
   input  logic            we_s,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] stat_o,
   output logic [XLEN-1:0] sview_o,
   output logic            flush_o
);
   localparam int              SD_POS = XLEN - 1;
   localparam logic [XLEN-1:0] SD_BIT = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] WMASK  = XLEN'(STAT_WMASK);
   localparam logic [XLEN-1:0] SMASK  = XLEN'(STAT_SVIEW) | SD_BIT;
   localparam logic [XLEN-1:0] FMASK  = XLEN'(STAT_FLUSH);
   localparam logic [XLEN-1:0] RVAL   = XLEN'(STAT_RESET);

   logic [XLEN-1:0] st_q, st_n, src;
   logic            we, dirty, flush_q, flush_d;

   assign we    = we_m | we_s;
   // summary bit is derived from the stored state fields
   assign dirty = (st_q[F_FPU_ST +: 2] == 2'b11) || (st_q[F_EXT_ST +: 2] == 2'b11);
   assign stat_o  = st_q | (dirty ? SD_BIT : '0);
   assign sview_o = stat_o & SMASK;

   always_comb begin
      src     = we_s ? ((stat_o & ~SMASK) | (wd & SMASK)) : wd;
      st_n    = (st_q & ~WMASK) | (src & WMASK);
      flush_d = we && (((st_n ^ st_q) & FMASK) != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= RVAL;
         flush_q <= 1'b0;
      end else begin
         flush_q <= flush_d;
         if (we) st_q <= st_n;
      end
   end
   assign flush_o = flush_q;

   AST_SD_FROM_FS: assert property (@(posedge clk) disable iff (rst)
      (we_m && wd[F_FPU_ST +: 2] == 2'b11) |=> stat_o[SD_POS]); // R3
   AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
      we |=> ((stat_o & ~WMASK & ~SD_BIT) == ($past(stat_o) & ~WMASK & ~SD_BIT))); // R2
   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
      flush_o |-> $past(we)); // R10
endmodule

// File: rtl/mtcsr_irq.sv
module mtcsr_irq
   import mtcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we_ien_m,
   input  logic            we_ien_s,
   input  logic            we_ip_m,
   input  logic            we_ip_s,
   input  logic            we_deleg,
   input  logic [XLEN-1:0] wd,
   input  logic [XLEN-1:0] wmask,
   input  logic [XLEN-1:0] hw_pend,
   input  logic [XLEN-1:0] hw_claim,
   output logic [XLEN-1:0] ien_o,
   output logic [XLEN-1:0] sien_o,
   output logic [XLEN-1:0] ip_o,
   output logic [XLEN-1:0] sip_o,
   output logic [XLEN-1:0] deleg_o
);
   localparam logic [XLEN-1:0] DMASK = XLEN'(INT_DELEGABLE);
   localparam logic [XLEN-1:0] AMASK = XLEN'(INT_ALL);

   logic [XLEN-1:0] ien_q, ip_q, ien_src, sw_m, ip_sw, hw_m;

   mtcsr_mreg #(.XLEN(XLEN), .MASK(DMASK)) u_deleg (
      .clk(clk), .rst(rst), .we(we_deleg), .wd(wd), .q_o(deleg_o));

   always_comb begin
      ien_src = we_ien_s ? ((ien_q & ~deleg_o) | (wd & deleg_o)) : wd;
      sw_m    = (we_ip_m ? wmask : (we_ip_s ? (wmask & deleg_o) : '0))
                & DMASK & ~hw_claim;
      ip_sw   = (ip_q & ~sw_m) | (wd & sw_m);
      hw_m    = hw_claim & AMASK;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ien_q <= '0;
         ip_q  <= '0;
      end else begin
         if (we_ien_m || we_ien_s) ien_q <= ien_src & AMASK;
         ip_q <= (ip_sw & ~hw_m) | (hw_pend & hw_m);
      end
   end

   assign ien_o  = ien_q;
   assign sien_o = ien_q & deleg_o;
   assign ip_o   = ip_q;
   assign sip_o  = ip_q & deleg_o;

   AST_IEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (ien_o & ~AMASK) == '0); // R6
   AST_SIE_KEEPS_UNDELEG: assert property (@(posedge clk) disable iff (rst)
      we_ien_s |=> ((ien_o & ~$past(deleg_o)) == ($past(ien_o) & ~$past(deleg_o)))); // R7
   AST_CLAIM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((ip_o & $past(hw_claim) & AMASK) == ($past(hw_pend) & $past(hw_claim) & AMASK))); // R8
endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
   import mtcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [XLEN-1:0] wr_data,
   input  logic [XLEN-1:0] wr_mask,
   input  logic            we_stat_m,
   input  logic            we_stat_s,
   input  logic            we_ien_m,
   input  logic            we_ien_s,
   input  logic            we_ipend_m,
   input  logic            we_ipend_s,
   input  logic            we_ideleg,
   input  logic            we_edeleg,
   input  logic            we_tvec_m,
   input  logic            we_tvec_s,
   input  logic [XLEN-1:0] hw_pend,
   input  logic [XLEN-1:0] hw_claim,
   output logic [XLEN-1:0] rd_stat_m,
   output logic [XLEN-1:0] rd_stat_s,
   output logic [XLEN-1:0] rd_ien_m,
   output logic [XLEN-1:0] rd_ien_s,
   output logic [XLEN-1:0] rd_ipend_m,
   output logic [XLEN-1:0] rd_ipend_s,
   output logic [XLEN-1:0] rd_ideleg,
   output logic [XLEN-1:0] rd_edeleg,
   output logic [XLEN-1:0] rd_tvec_m,
   output logic [XLEN-1:0] rd_tvec_s,
   output logic            flush_req
);
   localparam int NVEC = 2;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("mtrap_csr_file: XLEN must be 32 or 64");
      end
   endgenerate

   logic [NVEC-1:0]           tv_we;
   logic [NVEC-1:0][XLEN-1:0] tv_q;

   mtcsr_status #(.XLEN(XLEN)) u_status (
      .clk(clk), .rst(rst), .we_m(we_stat_m), .we_s(we_stat_s), .wd(wr_data),
      .stat_o(rd_stat_m), .sview_o(rd_stat_s), .flush_o(flush_req));

   mtcsr_irq #(.XLEN(XLEN)) u_irq (
      .clk(clk), .rst(rst), .we_ien_m(we_ien_m), .we_ien_s(we_ien_s),
      .we_ip_m(we_ipend_m), .we_ip_s(we_ipend_s), .we_deleg(we_ideleg),
      .wd(wr_data), .wmask(wr_mask), .hw_pend(hw_pend), .hw_claim(hw_claim),
      .ien_o(rd_ien_m), .sien_o(rd_ien_s), .ip_o(rd_ipend_m), .sip_o(rd_ipend_s),
      .deleg_o(rd_ideleg));

   mtcsr_mreg #(.XLEN(XLEN), .MASK(XLEN'(EXC_DELEGABLE))) u_edeleg (
      .clk(clk), .rst(rst), .we(we_edeleg), .wd(wr_data), .q_o(rd_edeleg));

   // index 0 is the machine vector, index 1 the supervisor vector
   assign tv_we = {we_tvec_s, we_tvec_m};

   generate
      for (genvar g = 0; g < NVEC; g++) begin : g_tvec
         mtcsr_tvec #(.XLEN(XLEN)) u_tvec (
            .clk(clk), .rst(rst), .we(tv_we[g]), .wd(wr_data), .vec_o(tv_q[g]));
      end
   endgenerate

   assign rd_tvec_m = tv_q[0];
   assign rd_tvec_s = tv_q[1];
endmodule

// File: tb/tb_mtrap_csr_file.sv
module tb_mtrap_csr_file;
   localparam logic [31:0] K_STW   = 32'h007E_79AA;
   localparam logic [31:0] K_SVIEW = 32'h800D_E133;
   localparam logic [31:0] K_FLUSH = 32'h000E_1800;
   localparam logic [31:0] K_INTD  = 32'h0000_0222;
   localparam logic [31:0] K_INTA  = 32'h0000_0AAA;
   localparam logic [31:0] K_EXC   = 32'h0000_BFFF;

   logic clk = 1'b0, rst = 1'b1;
   logic [31:0] wr_data = '0, wr_mask = '0, hw_pend = '0, hw_claim = '0;
   logic we_stat_m = 0, we_stat_s = 0, we_ien_m = 0, we_ien_s = 0;
   logic we_ipend_m = 0, we_ipend_s = 0, we_ideleg = 0, we_edeleg = 0;
   logic we_tvec_m = 0, we_tvec_s = 0;
   logic [31:0] rd_stat_m, rd_stat_s, rd_ien_m, rd_ien_s, rd_ipend_m, rd_ipend_s;
   logic [31:0] rd_ideleg, rd_edeleg, rd_tvec_m, rd_tvec_s;
   logic flush_req;

   int n_run = 0, n_fail = 0;
   logic done = 1'b0;

   logic [31:0] m_st, m_ien, m_dl, m_ip, m_ed, m_tvm, m_tvs;
   logic        m_fl;

   always #4 clk = ~clk;

   mtrap_csr_file #(.XLEN(32)) dut (.*);

   function automatic logic [31:0] st_full(input logic [31:0] s);
      logic d;
      d = (s[14:13] == 2'b11) || (s[16:15] == 2'b11);
      return s | {d, 31'b0};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2", "stat_m", rd_stat_m, st_full(m_st));
      chk("R3", "summary", {31'b0, rd_stat_m[31]},
          {31'b0, (m_st[14:13] == 2'b11) || (m_st[16:15] == 2'b11)});
      chk("R4", "stat_s", rd_stat_s, st_full(m_st) & K_SVIEW);
      chk("R6", "ien_m", rd_ien_m, m_ien);
      chk("R7", "ien_s", rd_ien_s, m_ien & m_dl);
      chk("R8", "ipend_m", rd_ipend_m, m_ip);
      chk("R8", "ipend_s", rd_ipend_s, m_ip & m_dl);
      chk("R6", "ideleg", rd_ideleg, m_dl);
      chk("R9", "edeleg", rd_edeleg, m_ed);
      chk("R5", "tvec_m", rd_tvec_m, m_tvm);
      chk("R5", "tvec_s", rd_tvec_s, m_tvs);
      chk("R10", "flush", {31'b0, flush_req}, {31'b0, m_fl});
   endtask

   // sel: 0..9 one register, anything else is an idle cycle
   task automatic step(input int sel, input logic [31:0] d, input logic [31:0] m,
                       input logic [31:0] hw, input logic [31:0] cl);
      logic [31:0] nst, src, swm, hm;
      wr_data = d; wr_mask = m; hw_pend = hw; hw_claim = cl;
      we_stat_m = (sel == 0); we_stat_s = (sel == 1); we_ien_m = (sel == 2);
      we_ien_s = (sel == 3); we_ipend_m = (sel == 4); we_ipend_s = (sel == 5);
      we_ideleg = (sel == 6); we_edeleg = (sel == 7); we_tvec_m = (sel == 8);
      we_tvec_s = (sel == 9);
      @(posedge clk);
      m_fl = 1'b0;
      swm = '0;
      if (sel == 0 || sel == 1) begin
         src = (sel == 1) ? ((st_full(m_st) & ~K_SVIEW) | (d & K_SVIEW)) : d;
         nst = (m_st & ~K_STW) | (src & K_STW);
         m_fl = ((nst ^ m_st) & K_FLUSH) != 0;
         m_st = nst;
      end
      if (sel == 2) m_ien = d & K_INTA;
      if (sel == 3) m_ien = ((m_ien & ~m_dl) | (d & m_dl)) & K_INTA;
      if (sel == 4) swm = m & K_INTD & ~cl;
      if (sel == 5) swm = m & m_dl & K_INTD & ~cl;
      m_ip = (m_ip & ~swm) | (d & swm);
      hm = cl & K_INTA;
      m_ip = (m_ip & ~hm) | (hw & hm);
      if (sel == 6) m_dl = d & K_INTD;
      if (sel == 7) m_ed = d & K_EXC;
      if (sel == 8 && d[1:0] < 2) m_tvm = d;
      if (sel == 9 && d[1:0] < 2) m_tvs = d;
      @(negedge clk);
      {we_stat_m, we_stat_s, we_ien_m, we_ien_s, we_ipend_m, we_ipend_s,
       we_ideleg, we_edeleg, we_tvec_m, we_tvec_s} = '0;
      check_all();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      m_st = 32'h0000_1800; m_ien = '0; m_dl = '0; m_ip = '0; m_ed = '0;
      m_tvm = '0; m_tvs = '0; m_fl = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state seen while reset is held
      chk("R1", "reset stat_m", rd_stat_m, 32'h0000_1800);
      chk("R1", "reset ien_m", rd_ien_m, 32'h0);
      chk("R1", "reset tvec_m", rd_tvec_m, 32'h0);
      chk("R1", "reset flush", {31'b0, flush_req}, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      check_all();

      // directed: all ones into status, then R3 summary and R10 pulse
      step(0, 32'hFFFF_FFFF, 0, 0, 0);
      chk("R3", "sd set", {31'b0, rd_stat_m[31]}, 32'h1);
      step(10, 0, 0, 0, 0);
      chk("R10", "pulse drop", {31'b0, flush_req}, 32'h0);
      // status write that changes no flush field gives no pulse (R10)
      step(0, 32'hFFFF_FFFF & ~32'h0000_6000, 0, 0, 0);
      chk("R10", "no pulse", {31'b0, flush_req}, 32'h0);
      // trap-vector modes, R5
      step(8, 32'h0000_1001, 0, 0, 0);
      step(8, 32'h0000_2002, 0, 0, 0);
      chk("R5", "mode2 drop", rd_tvec_m, 32'h0000_1001);
      step(9, 32'h0000_3000, 0, 0, 0);
      step(9, 32'h0000_4003, 0, 0, 0);
      chk("R5", "mode3 drop", rd_tvec_s, 32'h0000_3000);
      // claimed bit resists software write, R8
      step(6, 32'hFFFF_FFFF, 0, 0, 0);
      step(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_0020);
      chk("R8", "claimed clear", rd_ipend_m, 32'h0000_0202);

      // sweep over all registers with arithmetic patterns
      for (int i = 0; i < 660; i++) begin
         logic [31:0] d, m, hw, cl;
         d  = (i * 32'h9E37_79B1) ^ (32'(i) << 24) ^ (32'(i) >> 1);
         m  = (i * 32'h85EB_CA6B) ^ 32'h5555_5555;
         hw = i * 32'hC2B2_AE35;
         cl = ((i % 4) == 0) ? '0 : (i * 32'h27D4_EB2F);
         step(i % 11, d, m, hw, cl);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule